// File: doc/BRIEF.md
# Watchdog Timer with Grace-Window Interrupt

This block is a free-running watchdog whose time-out length is chosen by a 2-bit select. Each time-out is a power of two clocks, offset by a base exponent parameter. Software keeps the system alive by pulsing a restart strobe before the count expires. When the count expires, the block does not reset the system straight away. It raises an interrupt flag and opens a grace window of a fixed number of clocks (512 by default). This gives a handler time to react.

A reset request goes to the system reset sequencer only when the whole grace window passes with no restart and the reset enable is high. The request lasts a fixed number of cycles (two by default). In the first of those cycles the block also emits a one-cycle strobe that lets the sequencer record a watchdog reset as the cause. When the request ends, the block clears its own count, window and interrupt flag and starts counting again. A restart inside the window cancels the pending reset. If the reset enable is low, the window expires with no effect and counting resumes from zero.

Top module: `wdog_grace`

## Requirements
- R1: While rst_ni is low, irq_o, rst_req_o and rst_flag_set_o are 0.
- R2: The time-out length is L = 2^(tsel_i + BASE_LOG) clocks, with BASE_LOG = 4 by default. irq_o rises on the L-th rising edge after reset release or after a restart.
- R3: A restart_i pulse seen at a clock edge before the time-out zeroes the count, so the time-out follows L edges after that edge.
- R4: Once set, irq_o stays at 1 until irq_clr_i is high at an edge. If a time-out and irq_clr_i occur at the same edge, the flag is set.
- R5: With rst_en_i high and no restart, rst_req_o rises GRACE_CYC edges (512 by default) after the edge that set irq_o.
- R6: rst_req_o stays high for exactly HOLD_CYC cycles (2 by default). rst_flag_set_o is high only in the first of those cycles.
- R7: A restart_i during the grace window cancels the pending reset and leaves irq_o set. The next reset request follows L + GRACE_CYC edges after that restart.
- R8: With rst_en_i low, the window ends with no reset request. The count restarts from zero, so the next time-out follows L edges after the window closes.
- R9: When the reset request ends, irq_o reads 0 and the count starts from zero, so the next time-out follows L edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Software restart strobe |
| tsel_i | input | 2 | Time-out select |
| rst_en_i | input | 1 | Allows a reset request at the end of the window |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Watchdog interrupt flag |
| rst_req_o | output | 1 | Reset request to the sequencer |
| rst_flag_set_o | output | 1 | One-cycle strobe that sets the watchdog reset-cause flag |

## Verification
The assertions check four rules on every cycle:
- the reset request is held for more than one cycle;
- the cause strobe only ever appears together with the first cycle of a request;
- a request never begins at an edge where the enable was low or a restart was seen;
- the interrupt flag falls only after a software clear or at the end of a reset request.

The exact cycle counts can only be shown by the bench's scenarios. These are the time-out length for each select value, the 512-clock window, the count after a restart or a disabled expiry, and the restart cancelling a pending reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_GRACE = 2'd1,
    ST_HOLD  = 2'd2
  } wdg_st_e;
endpackage

// File: rtl/wdg_tick_cnt.sv
module wdg_tick_cnt #(
  parameter int BASE_LOG = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] tsel_i,
  output logic             hit_o
);
  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = BASE_LOG + NSEL;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1 [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_m1[g] = CW'((64'd1 << (BASE_LOG + g)) - 64'd1);
  end

  // >= keeps a lowered select from waiting a full wrap
  assign hit_o = !clr_i && (cnt_q >= lim_m1[tsel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_span_cnt.sv
module wdg_span_cnt #(
  parameter int LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int W = (LEN > 2) ? $clog2(LEN) : 1;

  logic [W-1:0] cnt_q;

  assign first_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
  parameter int BASE_LOG  = 4,
  parameter int GRACE_CYC = 512,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] tsel_i,
  input  logic       rst_en_i,
  input  logic       irq_clr_i,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       rst_flag_set_o
);
  import wdg_pkg::*;

  wdg_st_e st_q, st_d;
  logic    irq_q, irq_d;
  logic    hit, win_last, win_first, hold_first, hold_last;
  logic    in_run, in_grace, in_hold;

  assign in_run   = (st_q == ST_RUN);
  assign in_grace = (st_q == ST_GRACE);
  assign in_hold  = (st_q == ST_HOLD);

  wdg_tick_cnt #(.BASE_LOG(BASE_LOG), .SEL_W(2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_run || restart_i),
    .tsel_i (tsel_i),
    .hit_o  (hit)
  );

  wdg_span_cnt #(.LEN(GRACE_CYC)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_grace),
    .first_o (win_first),
    .last_o  (win_last)
  );

  wdg_span_cnt #(.LEN(HOLD_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_hold),
    .first_o (hold_first),
    .last_o  (hold_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (!restart_i && hit) st_d = ST_GRACE;
      ST_GRACE: begin
        if (restart_i)     st_d = ST_RUN;
        else if (win_last) st_d = rst_en_i ? ST_HOLD : ST_RUN;
      end
      ST_HOLD:  if (hold_last) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (in_run && !restart_i && hit) irq_d = 1'b1;
    else if (hold_last)              irq_d = 1'b0;
    else if (irq_clr_i)              irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o          = irq_q;
  assign rst_req_o      = in_hold;
  assign rst_flag_set_o = hold_first;

  logic unused_win_first;
  assign unused_win_first = win_first;
endmodule

// File: rtl/wdog_grace_chk.sv
module wdog_grace_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic [1:0] tsel_i,
  input logic       rst_en_i,
  input logic       irq_clr_i,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       rst_flag_set_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o); // R6

  AST_FLAG_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_flag_set_o |-> rst_req_o); // R6

  AST_FLAG_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> rst_flag_set_o); // R6

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_flag_set_o |=> !rst_flag_set_o); // R6

  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(rst_en_i)); // R8

  AST_REQ_NOT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> !$past(restart_i)); // R7

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> ($past(irq_clr_i) || $past(rst_req_o))); // R4

  logic unused_sel;
  assign unused_sel = ^tsel_i;
endmodule

bind wdog_grace wdog_grace_chk u_chk (.*);

// File: tb/tb_wdog_grace.sv
module tb_wdog_grace;
  localparam int BASE_LOG = 4;
  localparam int G        = 512;
  localparam int H        = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       restart_i = 1'b0;
  logic [1:0] tsel_i = 2'd0;
  logic       rst_en_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       irq_o, rst_req_o, rst_flag_set_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  wdog_grace #(.BASE_LOG(BASE_LOG), .GRACE_CYC(G), .HOLD_CYC(H)) dut (
    .clk_i, .rst_ni, .restart_i, .tsel_i, .rst_en_i, .irq_clr_i,
    .irq_o, .rst_req_o, .rst_flag_set_o
  );

  // {tsel, rst_en}
  localparam logic [2:0] VEC [4] = '{3'b001, 3'b111, 3'b010, 3'b101};

  function automatic int lim(input logic [1:0] s);
    return 1 << (int'(s) + BASE_LOG);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset(input logic [1:0] s, input logic en);
    @(negedge clk_i);
    rst_ni = 1'b0; restart_i = 1'b0; irq_clr_i = 1'b0;
    tsel_i = s; rst_en_i = en;
    repeat (3) @(negedge clk_i);
    chk(!irq_o && !rst_req_o && !rst_flag_set_o, "R1",
        {irq_o, rst_req_o, rst_flag_set_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic to_irq(output int n);
    n = 0;
    while (!irq_o && n < 5000) begin step(); n++; end
  endtask

  task automatic to_req(input int lmt, output int n);
    n = 0;
    while (!rst_req_o && n < lmt) begin step(); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, m, l;
    for (int i = 0; i < 4; i++) begin
      do_reset(VEC[i][2:1], VEC[i][0]);
      l = lim(VEC[i][2:1]);
      to_irq(n);
      chk(n == l, "R2", n, l);
      to_req(G + 20, m);
      if (VEC[i][0]) begin
        chk(m == G, "R5", m, G);
        chk(rst_flag_set_o == 1'b1, "R6", rst_flag_set_o, 1);
        step();
        chk(rst_req_o && !rst_flag_set_o, "R6", {rst_req_o, rst_flag_set_o}, 2);
        step();
        chk(!rst_req_o, "R6", rst_req_o, 0);
        chk(!irq_o, "R9", irq_o, 0);
        to_irq(n);
        chk(n == l, "R9", n, l);
      end else begin
        chk(!rst_req_o && m == G + 20, "R8", m, G + 20);
      end
    end

    // R3: restart before time-out
    do_reset(2'd2, 1'b0);
    repeat (40) step();
    restart_i = 1'b1; step(); restart_i = 1'b0;
    to_irq(n);
    chk(n == lim(2'd2), "R3", n, lim(2'd2));

    // R4: clear wins over nothing, set wins over clear
    do_reset(2'd0, 1'b0);
    irq_clr_i = 1'b1;
    to_irq(n);
    chk(n == 16 && irq_o, "R4", n, 16);
    step();
    chk(!irq_o, "R4", irq_o, 0);
    irq_clr_i = 1'b0;

    // R8: disabled expiry resumes counting from zero
    do_reset(2'd0, 1'b0);
    to_irq(n);
    irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    chk(!irq_o, "R4", irq_o, 0);
    to_irq(n);
    chk(n == 16 + G - 1, "R8", n, 16 + G - 1);
    chk(!rst_req_o, "R8", rst_req_o, 0);

    // R7: restart in window cancels reset, irq kept
    do_reset(2'd1, 1'b1);
    to_irq(n);
    repeat (100) step();
    restart_i = 1'b1; step(); restart_i = 1'b0;
    chk(irq_o == 1'b1, "R7", irq_o, 1);
    to_req(5000, m);
    chk(m == 32 + G, "R7", m, 32 + G);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule